// File: doc/BRIEF.md
# Sampling Timebase with Power-Down Width Qualifier

This block produces every timing reference a voice record/playback controller needs, all from one system clock. The sample rate comes from one of two enable sources. The first is an internal oscillator enable that is used as it is. The second is an external clock enable that is first divided by two, so its duty cycle has no effect. A prescaler turns the chosen source into a one-cycle sample strobe. Slower timers then count sample strobes and produce three outputs: a segment tick at every segment boundary, a ready flag that rises once the wake-up delay has passed, and a fixed-length message-end pulse.

The block also filters the asynchronous power-down request. The request is synchronised with two flops and then qualified against a minimum width that depends on the controller's operating mode. When the device is idle, one synchronised cycle is enough. In record mode and in playback mode, the request must span a mode-specific number of sample periods. A qualified request raises a one-cycle interrupt for the controller. It then holds every counter at zero until the request is released, and the wake-up delay restarts after the release.

All lengths are parameters counted in sample periods. The defaults (64 source cycles per sample, 800-sample segments, 150-sample wake-up, 100-sample end pulse, 200/100-sample record/playback minimum widths) give both supported sample rates when the matching source clock is applied.

Top module: `smpl_timebase`

## Requirements
- R1: While reset is asserted, sample_stb_o, seg_tick_o, ready_o, end_pulse_o and dn_intr_o are all 0.
- R2: With ext_sel_i=0, sample_stb_o is a one-cycle pulse issued once every DIV_RATIO cycles in which osc_en_i is 1.
- R3: With ext_sel_i=1, osc_en_i is ignored and ext_clk_en_i is divided by two before the prescaler, so sample_stb_o comes once every 2*DIV_RATIO cycles in which ext_clk_en_i is 1, however those cycles are spaced.
- R4: seg_tick_o pulses once every SEG_SAMPLES sample strobes, always in the same cycle as a sample strobe.
- R5: ready_o is 0 after reset and after every qualified power-down. It rises in the cycle after the WAKE_SAMPLES-th sample strobe counted from reset release or from the release of the power-down request. It falls in the cycle after dn_intr_o.
- R6: A 1 on msg_end_req_i while no end pulse is active sets end_pulse_o in the next cycle. end_pulse_o stays 1 for END_SAMPLES sample strobes. Requests made while the pulse is active are ignored.
- R7: With op_mode_i = 2'b00 (idle), or with 2'b11 (treated as idle), a request on pwrdn_i that is seen high by the two-flop synchroniser for at least one cycle is qualified.
- R8: With op_mode_i = 2'b01 (record), a request is qualified only once REC_MIN_SAMPLES sample strobes have occurred while the synchronised request is high. A shorter request is ignored and leaves ready_o at 1.
- R9: With op_mode_i = 2'b10 (playback), the minimum is PLAY_MIN_SAMPLES sample strobes. A shorter request is ignored and leaves ready_o at 1.
- R10: A qualified request produces exactly one one-cycle dn_intr_o pulse. No sample strobe or segment tick is produced after it until the request has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_sel_i | input | 1 | 1 selects the external clock enable, 0 the oscillator enable |
| osc_en_i | input | 1 | Internal oscillator enable, one cycle per oscillator period |
| ext_clk_en_i | input | 1 | External clock enable, one cycle per external clock period |
| op_mode_i | input | 2 | Controller mode: 00 idle, 01 record, 10 playback, 11 idle |
| pwrdn_i | input | 1 | Asynchronous power-down request, active high |
| msg_end_req_i | input | 1 | Start request for the message-end pulse |
| sample_stb_o | output | 1 | One-cycle sample strobe |
| seg_tick_o | output | 1 | One-cycle segment boundary tick |
| ready_o | output | 1 | Wake-up delay elapsed |
| end_pulse_o | output | 1 | Fixed-length message-end pulse |
| dn_intr_o | output | 1 | One-cycle qualified power-down interrupt |

## Verification
The prescaler is driven by three source patterns: a continuous oscillator enable, a continuous external enable, and an external enable on every other cycle. Measured strobe gaps of DIV_RATIO, twice DIV_RATIO and four times DIV_RATIO show the source selection, the divide-by-two and the independence from enable spacing. Power-down requests are tabled as (mode, width) pairs on both sides of each mode's minimum, including a width of exactly the minimum. Whether an interrupt appears and whether ready_o stays high then separate ignored requests from qualified ones. A second end-pulse request made during an active pulse, and an idle request held over many cycles, check that retriggering is ignored and that all timers are frozen.

// File: rtl/smpl_timebase_pkg.sv
package smpl_timebase_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_REC   = 2'b01,
    OP_PLAY  = 2'b10,
    OP_SPARE = 2'b11
  } op_mode_e;

  // bits needed for a counter holding 0 .. n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/smpl_clk_src.sv
module smpl_clk_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ext_sel_i,
  input  logic osc_en_i,
  input  logic ext_clk_en_i,
  output logic div_en_o
);

  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (hold_i) begin
      phase_d = 1'b0;
    end else if (ext_sel_i && ext_clk_en_i) begin
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // every second external enable passes; the oscillator enable passes as is
  assign div_en_o = ext_sel_i ? (ext_clk_en_i && phase_q) : osc_en_i;

endmodule

// File: rtl/smpl_prescale.sv
module smpl_prescale
  import smpl_timebase_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic en_i,
  output logic stb_o
);

  localparam int unsigned CW = cnt_w(DIV_RATIO);
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = en_i && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (hold_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign stb_o = wrap && !hold_i;

endmodule

// File: rtl/smpl_dn_qual.sv
module smpl_dn_qual
  import smpl_timebase_pkg::*;
#(
  parameter int unsigned REC_MIN_SAMPLES  = 200,
  parameter int unsigned PLAY_MIN_SAMPLES = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwrdn_i,
  input  logic [1:0] op_mode_i,
  input  logic       stb_i,
  output logic       intr_o,
  output logic       down_o
);

  localparam int unsigned MAXN = (REC_MIN_SAMPLES > PLAY_MIN_SAMPLES) ?
                                 REC_MIN_SAMPLES : PLAY_MIN_SAMPLES;
  localparam int unsigned NW = cnt_w(MAXN + 1);
  localparam logic [NW-1:0] REC_N  = NW'(REC_MIN_SAMPLES);
  localparam logic [NW-1:0] PLAY_N = NW'(PLAY_MIN_SAMPLES);

  logic          sync1_q, sync2_q;
  logic [NW-1:0] wid_q, wid_d;
  logic          down_q, down_d;
  logic          intr_q;
  logic [NW-1:0] need;
  logic          fire;

  // two-flop synchroniser for the asynchronous request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pwrdn_i;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    unique case (op_mode_e'(op_mode_i))
      OP_REC:  need = REC_N;
      OP_PLAY: need = PLAY_N;
      default: need = '0;
    endcase
  end

  always_comb begin
    fire = 1'b0;
    if (sync2_q && !down_q) begin
      if (need == '0) begin
        fire = 1'b1;
      end else if (stb_i && (wid_q >= need - 1'b1)) begin
        fire = 1'b1;
      end
    end
  end

  always_comb begin
    wid_d = wid_q;
    if (!sync2_q || down_q) begin
      wid_d = '0;
    end else if (stb_i && (wid_q != {NW{1'b1}})) begin
      wid_d = wid_q + 1'b1;
    end
    down_d = down_q ? sync2_q : fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q  <= '0;
      down_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      wid_q  <= wid_d;
      down_q <= down_d;
      intr_q <= fire;
    end
  end

  assign intr_o = intr_q;
  assign down_o = down_q;

endmodule

// File: rtl/smpl_timers.sv
module smpl_timers
  import smpl_timebase_pkg::*;
#(
  parameter int unsigned SEG_SAMPLES  = 800,
  parameter int unsigned WAKE_SAMPLES = 150,
  parameter int unsigned END_SAMPLES  = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic stb_i,
  input  logic end_req_i,
  output logic seg_tick_o,
  output logic ready_o,
  output logic end_pulse_o
);

  localparam int unsigned SW = cnt_w(SEG_SAMPLES);
  localparam int unsigned WW = cnt_w(WAKE_SAMPLES);
  localparam int unsigned EW = cnt_w(END_SAMPLES);
  localparam logic [SW-1:0] SEG_LAST  = SW'(SEG_SAMPLES - 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_SAMPLES - 1);
  localparam logic [EW-1:0] END_LAST  = EW'(END_SAMPLES - 1);

  logic [SW-1:0] seg_q, seg_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          rdy_q, rdy_d;
  logic [EW-1:0] end_q, end_d;
  logic          act_q, act_d;
  logic          seg_last;

  // segment counter
  always_comb begin
    seg_last = stb_i && (seg_q == SEG_LAST);
    seg_d    = seg_q;
    if (hold_i) begin
      seg_d = '0;
    end else if (stb_i) begin
      seg_d = seg_last ? '0 : seg_q + 1'b1;
    end
  end

  // wake-up delay
  always_comb begin
    wake_d = wake_q;
    rdy_d  = rdy_q;
    if (hold_i) begin
      wake_d = '0;
      rdy_d  = 1'b0;
    end else if (!rdy_q && stb_i) begin
      if (wake_q == WAKE_LAST) begin
        wake_d = '0;
        rdy_d  = 1'b1;
      end else begin
        wake_d = wake_q + 1'b1;
      end
    end
  end

  // message-end pulse, not retriggerable
  always_comb begin
    end_d = end_q;
    act_d = act_q;
    if (hold_i) begin
      end_d = '0;
      act_d = 1'b0;
    end else if (!act_q) begin
      if (end_req_i) begin
        end_d = '0;
        act_d = 1'b1;
      end
    end else if (stb_i) begin
      if (end_q == END_LAST) begin
        end_d = '0;
        act_d = 1'b0;
      end else begin
        end_d = end_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= '0;
      wake_q <= '0;
      rdy_q  <= 1'b0;
      end_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      wake_q <= wake_d;
      rdy_q  <= rdy_d;
      end_q  <= end_d;
      act_q  <= act_d;
    end
  end

  assign seg_tick_o  = seg_last && !hold_i;
  assign ready_o     = rdy_q;
  assign end_pulse_o = act_q;

endmodule

// File: rtl/smpl_timebase.sv
module smpl_timebase #(
  parameter int unsigned DIV_RATIO        = 64,
  parameter int unsigned SEG_SAMPLES      = 800,
  parameter int unsigned WAKE_SAMPLES     = 150,
  parameter int unsigned END_SAMPLES      = 100,
  parameter int unsigned REC_MIN_SAMPLES  = 200,
  parameter int unsigned PLAY_MIN_SAMPLES = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_sel_i,
  input  logic       osc_en_i,
  input  logic       ext_clk_en_i,
  input  logic [1:0] op_mode_i,
  input  logic       pwrdn_i,
  input  logic       msg_end_req_i,
  output logic       sample_stb_o,
  output logic       seg_tick_o,
  output logic       ready_o,
  output logic       end_pulse_o,
  output logic       dn_intr_o
);

  logic rst_s1_q, rst_s2_q;
  logic rst_n;
  logic hold;
  logic div_en;
  logic stb;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q;

  smpl_clk_src u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .hold_i       (hold),
    .ext_sel_i    (ext_sel_i),
    .osc_en_i     (osc_en_i),
    .ext_clk_en_i (ext_clk_en_i),
    .div_en_o     (div_en)
  );

  smpl_prescale #(.DIV_RATIO(DIV_RATIO)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .hold_i (hold),
    .en_i   (div_en),
    .stb_o  (stb)
  );

  smpl_dn_qual #(
    .REC_MIN_SAMPLES  (REC_MIN_SAMPLES),
    .PLAY_MIN_SAMPLES (PLAY_MIN_SAMPLES)
  ) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pwrdn_i   (pwrdn_i),
    .op_mode_i (op_mode_i),
    .stb_i     (stb),
    .intr_o    (dn_intr_o),
    .down_o    (hold)
  );

  smpl_timers #(
    .SEG_SAMPLES  (SEG_SAMPLES),
    .WAKE_SAMPLES (WAKE_SAMPLES),
    .END_SAMPLES  (END_SAMPLES)
  ) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .hold_i      (hold),
    .stb_i       (stb),
    .end_req_i   (msg_end_req_i),
    .seg_tick_o  (seg_tick_o),
    .ready_o     (ready_o),
    .end_pulse_o (end_pulse_o)
  );

  assign sample_stb_o = stb;

endmodule

// File: rtl/smpl_timebase_chk.sv
module smpl_timebase_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_stb_o,
  input logic seg_tick_o,
  input logic ready_o,
  input logic end_pulse_o,
  input logic dn_intr_o,
  input logic msg_end_req_i
);

  assert_stb_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |=> !sample_stb_o);

  assert_seg_on_stb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_tick_o |-> sample_stb_o);

  assert_ready_after_stb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(sample_stb_o));

  assert_intr_drops_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_intr_o |=> !ready_o);

  assert_end_needs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_pulse_o) |-> $past(msg_end_req_i));

  assert_intr_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_intr_o |=> !dn_intr_o);

  assert_frozen_on_intr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_intr_o |-> (!sample_stb_o && !seg_tick_o));

endmodule

bind smpl_timebase smpl_timebase_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_stb_o  (sample_stb_o),
  .seg_tick_o    (seg_tick_o),
  .ready_o       (ready_o),
  .end_pulse_o   (end_pulse_o),
  .dn_intr_o     (dn_intr_o),
  .msg_end_req_i (msg_end_req_i)
);

// File: tb/smpl_timebase_tb_top.sv
`timescale 1ns/1ps
module smpl_timebase_tb_top;

  localparam int DIV   = 4;
  localparam int SEG   = 10;
  localparam int WAKE  = 6;
  localparam int ENDN  = 5;
  localparam int RECM  = 8;
  localparam int PLAYM = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_sel, osc_en, ext_clk_en, pwrdn, end_req;
  logic [1:0] mode;
  logic       sample_stb_o, seg_tick_o, ready_o, end_pulse_o, dn_intr_o;
  int         xmode;
  logic       xph;

  always #10 clk = ~clk;

  smpl_timebase #(
    .DIV_RATIO(DIV), .SEG_SAMPLES(SEG), .WAKE_SAMPLES(WAKE),
    .END_SAMPLES(ENDN), .REC_MIN_SAMPLES(RECM), .PLAY_MIN_SAMPLES(PLAYM)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_sel_i(ext_sel), .osc_en_i(osc_en),
    .ext_clk_en_i(ext_clk_en), .op_mode_i(mode), .pwrdn_i(pwrdn),
    .msg_end_req_i(end_req), .sample_stb_o(sample_stb_o),
    .seg_tick_o(seg_tick_o), .ready_o(ready_o), .end_pulse_o(end_pulse_o),
    .dn_intr_o(dn_intr_o)
  );

  // external enable pattern: 0 off, 1 every cycle, 2 every other cycle
  initial xph = 1'b0;
  always @(posedge clk) begin
    #1;
    xph = ~xph;
    ext_clk_en = (xmode == 1) || ((xmode == 2) && xph);
  end

  int n_run = 0;
  int n_fail = 0;
  int stb_cnt, seg_cnt, intr_cnt, rdy_low, end_stb, end_rises;
  logic end_prev = 1'b0;

  always @(negedge clk) begin
    if (sample_stb_o) stb_cnt++;
    if (seg_tick_o) seg_cnt++;
    if (dn_intr_o) intr_cnt++;
    if (!ready_o) rdy_low++;
    if (end_pulse_o && sample_stb_o) end_stb++;
    if (end_pulse_o && !end_prev) end_rises++;
    end_prev = end_pulse_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_counts();
    stb_cnt = 0; seg_cnt = 0; intr_cnt = 0; rdy_low = 0;
    end_stb = 0; end_rises = 0;
  endtask

  task automatic gap_stb(output int g);
    int c = 0;
    do @(negedge clk); while (!sample_stb_o);
    do begin @(negedge clk); c++; end while (!sample_stb_o);
    g = c;
  endtask

  task automatic gap_seg(output int g);
    int c = 0;
    do @(negedge clk); while (!seg_tick_o);
    do begin @(negedge clk); c++; end while (!seg_tick_o);
    g = c;
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!ready_o);
  endtask

  task automatic stb_until_ready(output int c);
    c = 0;
    do @(negedge clk); while (ready_o);
    while (!ready_o) begin
      if (sample_stb_o) c++;
      @(negedge clk);
    end
  endtask

  // {mode[1:0], width in cycles[7:0], interrupt expected}
  localparam logic [10:0] VECS [10] = '{
    {2'b00, 8'd1,  1'b1},   // R7 idle, one cycle
    {2'b00, 8'd3,  1'b1},   // R7
    {2'b11, 8'd2,  1'b1},   // R7 spare code acts as idle
    {2'b01, 8'd24, 1'b0},   // R8 at most 6 strobes
    {2'b01, 8'd28, 1'b0},   // R8 at most 7 strobes
    {2'b01, 8'd32, 1'b1},   // R8 exactly 8 strobes
    {2'b01, 8'd40, 1'b1},   // R8
    {2'b10, 8'd12, 1'b0},   // R9 at most 3 strobes
    {2'b10, 8'd16, 1'b1},   // R9 exactly 4 strobes
    {2'b10, 8'd20, 1'b1}    // R9
  };

  initial begin
    repeat (60000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int g, c;
    string tag;
    rst_n = 1'b0; ext_sel = 1'b0; osc_en = 1'b0; pwrdn = 1'b0;
    end_req = 1'b0; mode = 2'b00; xmode = 0;
    clear_counts();
    repeat (3) step();
    @(negedge clk);
    chk("R1 outputs in reset", {27'd0, sample_stb_o, seg_tick_o, ready_o,
        end_pulse_o, dn_intr_o}, 0);

    step();
    rst_n = 1'b1; osc_en = 1'b1;
    // R5 wake-up after reset
    c = 0;
    while (!ready_o) begin
      @(negedge clk);
      if (sample_stb_o && !ready_o) c++;
    end
    chk("R5 strobes before ready after reset", c, WAKE);

    gap_stb(g);
    chk("R2 internal strobe gap", g, DIV);
    gap_seg(g);
    chk("R4 segment tick gap", g, SEG * DIV);

    step(); ext_sel = 1'b1; xmode = 1;
    gap_stb(g); gap_stb(g);
    chk("R3 external continuous gap", g, 2 * DIV);
    step(); xmode = 2;
    gap_stb(g); gap_stb(g);
    chk("R3 external sparse gap", g, 4 * DIV);
    step(); ext_sel = 1'b0; xmode = 0;
    gap_stb(g); gap_stb(g);
    chk("R2 back on oscillator gap", g, DIV);

    // R6 end pulse with a retrigger attempt
    wait_ready();
    step(); clear_counts(); end_req = 1'b1;
    step(); end_req = 1'b0;
    @(negedge clk);
    chk("R6 pulse starts next cycle", int'(end_pulse_o), 1);
    repeat (6) step();
    end_req = 1'b1;
    step(); end_req = 1'b0;
    do @(negedge clk); while (end_pulse_o);
    chk("R6 pulse length in strobes", end_stb, ENDN);
    chk("R6 retrigger ignored", end_rises, 1);

    // power-down qualification table
    for (int i = 0; i < 10; i++) begin
      logic [1:0] vm;
      int         vw;
      logic       ve;
      vm = VECS[i][10:9];
      vw = int'(VECS[i][8:1]);
      ve = VECS[i][0];
      tag = (vm == 2'b01) ? "R8" : (vm == 2'b10) ? "R9" : "R7";
      wait_ready();
      step(); mode = vm; clear_counts(); pwrdn = 1'b1;
      repeat (vw) step();
      pwrdn = 1'b0;
      if (ve) begin
        stb_until_ready(c);
        chk({tag, " qualified interrupt count"}, intr_cnt, 1);
        chk("R5 strobes before ready after release", c, WAKE);
      end else begin
        repeat (8) step();
        chk({tag, " short request no interrupt"}, intr_cnt, 0);
        chk({tag, " short request keeps ready"}, rdy_low, 0);
      end
    end

    // R10 frozen while held down
    wait_ready();
    step(); mode = 2'b00; pwrdn = 1'b1;
    repeat (4) step();
    clear_counts();
    repeat (30) step();
    chk("R10 no strobes while down", stb_cnt, 0);
    chk("R10 no ticks while down", seg_cnt, 0);
    chk("R10 single interrupt", intr_cnt, 0);
    pwrdn = 1'b0;
    wait_ready();
    gap_seg(g);
    chk("R4 segment gap after wake", g, SEG * DIV);

    // R1 again: reset mid-run clears outputs
    step(); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 outputs after mid-run reset", {27'd0, sample_stb_o, seg_tick_o,
        ready_o, end_pulse_o, dn_intr_o}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule